// File: doc/BRIEF.md
# PS/2 Host Command Decoder

This block sits behind the host's two byte-wide ports of a legacy PS/2 keyboard controller. A write with the port select high carries a controller command; a write with the select low carries a data byte. Some commands act at once: reading back the mode register, probing or gating the auxiliary channel, and asking for a system reset. Three commands only arm the decoder. The next data-port write then becomes their argument, and what that write does depends on which command is armed.

The decoder keeps the 8-bit mode register and the armed command. Its results are push requests toward an external keyboard queue and an external auxiliary queue, a one-cycle strobe that hands a byte to the auxiliary device, and a one-cycle system-reset pulse. When one write produces several pushes, a small sequencer sends them one per cycle and holds `busy` high. Writes that arrive while `busy` is high are dropped.

Top module: `kbc_host_decoder`

## Requirements
- R1: After reset the mode register reads 0x03, `busy` is low and no push, forward or reset strobe is active.
- R2: Command 0x20 pushes the mode register's current value into the keyboard queue as one push in the cycle after the write.
- R3: Command 0x60 arms a mode load; the next data-port write copies its byte into the mode register, which shows the new value in the cycle after that write.
- R4: Command 0xD3 arms an echo; the next data-port write pushes its byte into the auxiliary queue, and 0xFA in the following cycle.
- R5: Command 0xD4 arms a forward; the next data-port write raises `auxFwdValid` for exactly one cycle with the byte on `auxFwdData`, and it pushes nothing.
- R6: Command 0xA9 pushes 0x00 into the auxiliary queue.
- R7: Command 0xA7 sets mode bit 5 (auxiliary channel off) and command 0xA8 clears it; the other mode bits keep their values.
- R8: Command 0xFE raises `sysResetPulse` for one cycle, in the cycle after the write.
- R9: A data-port write with nothing armed pushes 0xFA, 0xAB and 0x41 into the keyboard queue, in that order, on three consecutive cycles.
- R10: Every data-port write disarms the pending command, so a second data write gives the R9 reply.
- R11: A command byte that is not listed in R2 to R8 produces no push or strobe, leaves the mode register unchanged and keeps any armed command.
- R12: While the pushes of one write are still outstanding beyond the current one, `busy` is high and writes on either port are ignored.
- R13: At most one of the two push requests is active in a cycle, and the results of an accepted write start in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| wrSel | input | 1 | 1 = command port, 0 = data port |
| wrData | input | 8 | Byte written |
| busy | output | 1 | A multi-push reply is in progress; writes are dropped |
| modeReg | output | 8 | Current mode register |
| kbdPushValid | output | 1 | Push request to the keyboard queue |
| kbdPushData | output | 8 | Byte for the keyboard queue |
| auxPushValid | output | 1 | Push request to the auxiliary queue |
| auxPushData | output | 8 | Byte for the auxiliary queue |
| auxFwdValid | output | 1 | One-cycle strobe: hand a byte to the auxiliary device |
| auxFwdData | output | 8 | Byte handed to the auxiliary device |
| sysResetPulse | output | 1 | One-cycle system reset request |

## Verification
Some properties are checked on every cycle. The two push requests never overlap. `busy` always comes with a push in flight. The mode register holds still in any cycle without an accepted write. Each forward or reset strobe traces back to an accepted write of the right kind one cycle earlier. Other behaviour shows only in the bench's scenarios: the exact bytes and their order, the argument meaning chosen by the armed command, disarming after a data write, an unknown command leaving an armed command intact, and writes dropped while `busy` is high.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEQ_MAX = 3;
  localparam int CNT_W   = $clog2(SEQ_MAX + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  // command codes seen on the command port
  localparam byte_t CMD_RD_MODE   = 8'h20;
  localparam byte_t CMD_WR_MODE   = 8'h60;
  localparam byte_t CMD_AUX_ECHO  = 8'hD3;
  localparam byte_t CMD_AUX_FWD   = 8'hD4;
  localparam byte_t CMD_AUX_PROBE = 8'hA9;
  localparam byte_t CMD_AUX_OFF   = 8'hA7;
  localparam byte_t CMD_AUX_ON    = 8'hA8;
  localparam byte_t CMD_SYS_RST   = 8'hFE;

  // reply bytes
  localparam byte_t BYTE_ACK    = 8'hFA;
  localparam byte_t BYTE_ID_HI  = 8'hAB;
  localparam byte_t BYTE_ID_LO  = 8'h41;
  localparam byte_t BYTE_AUX_OK = 8'h00;

  localparam int    AUX_OFF_BIT = 5;
  localparam byte_t MODE_INIT   = 8'h03;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_MODE = 2'd1,
    PEND_ECHO = 2'd2,
    PEND_FWD  = 2'd3
  } pend_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  modeLoad;
    logic  auxOff;
    logic  auxOn;
    logic  pendLoad;
    pend_e pendNext;
    logic  fwdFire;
    logic  rstFire;
    byte_t dataByte;
  } dpStrobe_t;

  // request to load the push sequencer
  typedef struct packed {
    logic                     load;
    logic                     toAux;
    logic [CNT_W-1:0]         count;
    byte_t [SEQ_MAX-1:0]      bytes;
  } seqReq_t;
endpackage

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
  import kbc_pkg::*;
(
  input  logic      wrEn,
  input  logic      wrSel,
  input  byte_t     wrData,
  input  logic      busy,
  input  pend_e     pendCur,
  input  byte_t     modeCur,
  output dpStrobe_t strobe,
  output seqReq_t   seq
);
  logic accept;
  assign accept = wrEn && !busy;

  always_comb begin
    strobe          = '0;
    seq             = '0;
    strobe.dataByte = wrData;
    if (accept && wrSel) begin
      unique case (wrData)
        CMD_RD_MODE: begin
          seq.load     = 1'b1;
          seq.toAux    = 1'b0;
          seq.count    = CNT_W'(1);
          seq.bytes[0] = modeCur;
        end
        CMD_WR_MODE: begin
          strobe.pendLoad = 1'b1;
          strobe.pendNext = PEND_MODE;
        end
        CMD_AUX_ECHO: begin
          strobe.pendLoad = 1'b1;
          strobe.pendNext = PEND_ECHO;
        end
        CMD_AUX_FWD: begin
          strobe.pendLoad = 1'b1;
          strobe.pendNext = PEND_FWD;
        end
        CMD_AUX_PROBE: begin
          seq.load     = 1'b1;
          seq.toAux    = 1'b1;
          seq.count    = CNT_W'(1);
          seq.bytes[0] = BYTE_AUX_OK;
        end
        CMD_AUX_OFF: strobe.auxOff  = 1'b1;
        CMD_AUX_ON:  strobe.auxOn   = 1'b1;
        CMD_SYS_RST: strobe.rstFire = 1'b1;
        default: ;
      endcase
    end else if (accept) begin
      strobe.pendLoad = 1'b1;
      strobe.pendNext = PEND_NONE;
      unique case (pendCur)
        PEND_MODE: strobe.modeLoad = 1'b1;
        PEND_ECHO: begin
          seq.load     = 1'b1;
          seq.toAux    = 1'b1;
          seq.count    = CNT_W'(2);
          seq.bytes[0] = wrData;
          seq.bytes[1] = BYTE_ACK;
        end
        PEND_FWD: strobe.fwdFire = 1'b1;
        default: begin
          seq.load     = 1'b1;
          seq.toAux    = 1'b0;
          seq.count    = CNT_W'(3);
          seq.bytes[0] = BYTE_ACK;
          seq.bytes[1] = BYTE_ID_HI;
          seq.bytes[2] = BYTE_ID_LO;
        end
      endcase
    end
  end
endmodule

// File: rtl/kbc_datapath.sv
module kbc_datapath
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RESET = MODE_INIT
) (
  input  logic      clk,
  input  logic      rst_n,
  input  dpStrobe_t strobe,
  output byte_t     modeQ,
  output pend_e     pendQ,
  output logic      fwdValidQ,
  output byte_t     fwdDataQ,
  output logic      rstPulseQ
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ     <= MODE_RESET;
      pendQ     <= PEND_NONE;
      fwdValidQ <= 1'b0;
      fwdDataQ  <= '0;
      rstPulseQ <= 1'b0;
    end else begin
      if (strobe.modeLoad)    modeQ <= strobe.dataByte;
      else if (strobe.auxOff) modeQ[AUX_OFF_BIT] <= 1'b1;
      else if (strobe.auxOn)  modeQ[AUX_OFF_BIT] <= 1'b0;
      if (strobe.pendLoad) pendQ <= strobe.pendNext;
      fwdValidQ <= strobe.fwdFire;
      if (strobe.fwdFire) fwdDataQ <= strobe.dataByte;
      rstPulseQ <= strobe.rstFire;
    end
  end
endmodule

// File: rtl/kbc_push_seq.sv
module kbc_push_seq
  import kbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seqReq_t req,
  output logic    kbdValid,
  output logic    auxValid,
  output byte_t   pushData,
  output logic    busy
);
  byte_t [SEQ_MAX-1:0] bufQ;
  logic [CNT_W-1:0]    remainQ;
  logic                toAuxQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bufQ    <= '0;
      remainQ <= '0;
      toAuxQ  <= 1'b0;
    end else if (req.load) begin
      bufQ    <= req.bytes;
      remainQ <= req.count;
      toAuxQ  <= req.toAux;
    end else if (remainQ != '0) begin
      for (int i = 0; i < SEQ_MAX - 1; i++) bufQ[i] <= bufQ[i+1];
      bufQ[SEQ_MAX-1] <= '0;
      remainQ <= remainQ - CNT_W'(1);
    end
  end

  assign kbdValid = (remainQ != '0) && !toAuxQ;
  assign auxValid = (remainQ != '0) && toAuxQ;
  assign pushData = bufQ[0];
  assign busy     = remainQ > CNT_W'(1);
endmodule

// File: rtl/kbc_host_decoder.sv
module kbc_host_decoder
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RESET = MODE_INIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic              busy,
  output logic [BYTE_W-1:0] modeReg,
  output logic              kbdPushValid,
  output logic [BYTE_W-1:0] kbdPushData,
  output logic              auxPushValid,
  output logic [BYTE_W-1:0] auxPushData,
  output logic              auxFwdValid,
  output logic [BYTE_W-1:0] auxFwdData,
  output logic              sysResetPulse
);
  dpStrobe_t strobe;
  seqReq_t   seq;
  pend_e     pendCur;
  byte_t     pushData;

  kbc_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .busy    (busy),
    .pendCur (pendCur),
    .modeCur (modeReg),
    .strobe  (strobe),
    .seq     (seq)
  );

  kbc_datapath #(.MODE_RESET(MODE_RESET)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .modeQ     (modeReg),
    .pendQ     (pendCur),
    .fwdValidQ (auxFwdValid),
    .fwdDataQ  (auxFwdData),
    .rstPulseQ (sysResetPulse)
  );

  kbc_push_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (seq),
    .kbdValid (kbdPushValid),
    .auxValid (auxPushValid),
    .pushData (pushData),
    .busy     (busy)
  );

  assign kbdPushData = pushData;
  assign auxPushData = pushData;
endmodule

// File: rtl/kbc_host_decoder_checker.sv
module kbc_host_decoder_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic       wrSel,
  input logic [7:0] wrData,
  input logic       busy,
  input logic [7:0] modeReg,
  input logic       kbdPushValid,
  input logic       auxPushValid,
  input logic       auxFwdValid,
  input logic [7:0] auxFwdData,
  input logic       sysResetPulse
);
  // R1: reset loads the mode register
  assert_reset_mode_R1: assert property (@(posedge clk)
    !rst_n |=> (modeReg == 8'h03));

  // R13: the two queues are never pushed together
  assert_push_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(kbdPushValid && auxPushValid));

  // R12: busy only while a push is being issued
  assert_busy_with_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (kbdPushValid || auxPushValid));

  // R12: busy promises another push in the next cycle
  assert_busy_continues_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (kbdPushValid || auxPushValid));

  // R11: mode changes only after an accepted write
  assert_mode_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && !busy) |=> $stable(modeReg));

  // R5: forward strobe follows an accepted data write carrying its byte
  assert_fwd_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auxFwdValid |-> ($past(wrEn && !busy && !wrSel) && auxFwdData == $past(wrData)));

  // R8: reset pulse follows an accepted 0xFE command
  assert_rst_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sysResetPulse |-> $past(wrEn && !busy && wrSel && wrData == 8'hFE));
endmodule

bind kbc_host_decoder kbc_host_decoder_checker u_chk (.*);

// File: tb/kbc_host_decoder_bench.sv
`timescale 1ns/1ps
module kbc_host_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       busy;
  logic [7:0] modeReg;
  logic       kbdPushValid, auxPushValid, auxFwdValid, sysResetPulse;
  logic [7:0] kbdPushData, auxPushData, auxFwdData;

  always #2 clk = ~clk;

  kbc_host_decoder u_kbc_host_decoder (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .busy(busy), .modeReg(modeReg),
    .kbdPushValid(kbdPushValid), .kbdPushData(kbdPushData),
    .auxPushValid(auxPushValid), .auxPushData(auxPushData),
    .auxFwdValid(auxFwdValid), .auxFwdData(auxFwdData),
    .sysResetPulse(sysResetPulse)
  );

  // kinds: 0 keyboard push, 1 aux push, 2 forward, 3 reset pulse
  typedef struct { int kind; logic [7:0] val; string tag; } item_t;
  item_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit monOn   = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input int kind, input logic [7:0] val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic observe(input int kind, input logic [7:0] val);
    item_t it;
    if (expQ.size() == 0) begin
      check(1'b0, $sformatf("unexpected event kind %0d", kind), val, 8'h00);
    end else begin
      it = expQ.pop_front();
      check(it.kind == kind && it.val == val,
            $sformatf("%s kind %0d/%0d", it.tag, kind, it.kind), val, it.val);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (monOn && rst_n) begin
      if (kbdPushValid && auxPushValid)
        check(1'b0, "R13 both queues pushed", 8'h01, 8'h00);
      if (kbdPushValid)  observe(0, kbdPushData);
      if (auxPushValid)  observe(1, auxPushData);
      if (auxFwdValid)   observe(2, auxFwdData);
      if (sysResetPulse) observe(3, 8'h00);
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, {tag, " all expected events seen"}, 8'(expQ.size()), 8'h00);
    expQ.delete();
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(modeReg == 8'h03, "R1 mode after reset", modeReg, 8'h03);
    check(!busy && !kbdPushValid && !auxPushValid && !auxFwdValid && !sysResetPulse,
          "R1 outputs idle", {3'b0, busy, kbdPushValid, auxPushValid, auxFwdValid, sysResetPulse}, 8'h00);
    monOn = 1'b1;

    // R2 read mode; R13 result one cycle after write
    expect_item(0, 8'h03, "R2 read mode");
    wr(1'b1, 8'h20);
    check(kbdPushValid && kbdPushData == 8'h03, "R13 push in cycle after write", kbdPushData, 8'h03);
    drain("R2");

    // R7 aux off / on
    wr(1'b1, 8'hA7);
    check(modeReg == 8'h23, "R7 aux off bit set", modeReg, 8'h23);
    expect_item(0, 8'h23, "R7 read back mode");
    wr(1'b1, 8'h20);
    wr(1'b1, 8'hA8);
    check(modeReg == 8'h03, "R7 aux off bit cleared", modeReg, 8'h03);
    drain("R7");

    // R3 write mode, R10 then plain data gives ID
    wr(1'b1, 8'h60);
    wr(1'b0, 8'h5C);
    check(modeReg == 8'h5C, "R3 mode loaded", modeReg, 8'h5C);
    wr(1'b1, 8'hA7);
    check(modeReg == 8'h7C, "R7 other bits kept", modeReg, 8'h7C);
    expect_item(0, 8'hFA, "R10 id ack");
    expect_item(0, 8'hAB, "R10 id hi");
    expect_item(0, 8'h41, "R10 id lo");
    wr(1'b0, 8'h11);
    check(modeReg == 8'h7C, "R10 mode untouched by second data", modeReg, 8'h7C);
    drain("R10");

    // R9 ID reply on consecutive cycles
    expect_item(0, 8'hFA, "R9 id ack");
    expect_item(0, 8'hAB, "R9 id hi");
    expect_item(0, 8'h41, "R9 id lo");
    wr(1'b0, 8'h00);
    check(kbdPushValid, "R9 push 1 present", {7'b0, kbdPushValid}, 8'h01);
    @(negedge clk);
    check(kbdPushValid, "R9 push 2 consecutive", {7'b0, kbdPushValid}, 8'h01);
    @(negedge clk);
    check(kbdPushValid, "R9 push 3 consecutive", {7'b0, kbdPushValid}, 8'h01);
    drain("R9");

    // R4 echo
    expect_item(1, 8'h77, "R4 echo byte");
    expect_item(1, 8'hFA, "R4 echo ack");
    wr(1'b1, 8'hD3);
    wr(1'b0, 8'h77);
    drain("R4");

    // R5 forward
    expect_item(2, 8'hE9, "R5 forward");
    wr(1'b1, 8'hD4);
    wr(1'b0, 8'hE9);
    check(auxFwdValid, "R5 strobe present", {7'b0, auxFwdValid}, 8'h01);
    @(negedge clk);
    check(!auxFwdValid, "R5 strobe one cycle", {7'b0, auxFwdValid}, 8'h00);
    drain("R5");

    // R6 probe
    expect_item(1, 8'h00, "R6 probe reply");
    wr(1'b1, 8'hA9);
    drain("R6");

    // R8 system reset
    expect_item(3, 8'h00, "R8 reset pulse");
    wr(1'b1, 8'hFE);
    check(sysResetPulse, "R8 pulse high", {7'b0, sysResetPulse}, 8'h01);
    @(negedge clk);
    check(!sysResetPulse, "R8 pulse single", {7'b0, sysResetPulse}, 8'h00);
    drain("R8");

    // R11 unknown command ignored, armed command kept
    wr(1'b1, 8'h55);
    check(modeReg == 8'h7C, "R11 mode unchanged", modeReg, 8'h7C);
    drain("R11 no events");
    wr(1'b1, 8'h60);
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h9A);
    check(modeReg == 8'h9A, "R11 armed command kept", modeReg, 8'h9A);
    drain("R11 armed");

    // R12 writes during busy are dropped
    expect_item(0, 8'hFA, "R12 id ack");
    expect_item(0, 8'hAB, "R12 id hi");
    expect_item(0, 8'h41, "R12 id lo");
    wr(1'b0, 8'h00);
    check(busy, "R12 busy during reply", {7'b0, busy}, 8'h01);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 8'hA9;
    @(negedge clk);
    wrSel = 1'b1; wrData = 8'h60;
    @(negedge clk);
    wrEn = 1'b0;
    wr(1'b0, 8'h33);
    check(modeReg == 8'h9A, "R12 dropped 0x60 left nothing armed", modeReg, 8'h9A);
    expect_item(0, 8'hFA, "R12 id after drop ack");
    expect_item(0, 8'hAB, "R12 id after drop hi");
    expect_item(0, 8'h41, "R12 id after drop lo");
    drain("R12");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule